// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital side of a dual-slope integrating converter. It runs from the oscillator clock and divides it by four to make a count clock. On that count clock it steps through four phases: auto-zero, signal integrate, de-integrate and zero-integrator. Each phase has its own enable output, and de-integrate has two, one for each reference polarity. These enables drive the analog switches. The only analog input it sees is the comparator, which reports on which side of zero the integrator output sits.

Signal integrate always lasts the same number of counts. At the end of it the comparator is sampled to fix the polarity, and that polarity picks the de-integrate enable. De-integrate counts in BCD decades until the comparator changes side. The count reached is the reading. It is loaded into an output latch together with a sign bit and an overrange flag. If the comparator never changes side within the window, the conversion is marked as overrange and the zero-integrator phase that follows is stretched. Auto-zero takes up whatever time is left over, so that every conversion takes the same number of oscillator clocks.

Top module: `dsc_sequencer`

## Requirements
- R1: While `rst` is high and in the clock after it, only `en_az` is high, and `rdg_dec`, `rdg_thou`, `rdg_neg` and `rdg_ovr` are all zero. The first auto-zero after reset lasts INT_COUNTS counts, which is 4000 clocks by default.
- R2: In every clock out of reset, exactly one of the five phase enables is high.
- R3: The count clock is the oscillator clock divided by DIV (4). Every phase starts and ends on a count boundary, so every phase length is a whole multiple of DIV clocks.
- R4: Signal integrate lasts exactly INT_COUNTS counts (4000 clocks).
- R5: `cmp_pos` is sampled on the last count of signal integrate. A 1 selects `en_de_pos` and latches `rdg_neg`=0. A 0 selects `en_de_neg` and latches `rdg_neg`=1.
- R6: De-integrate ends at the first count on which `cmp_pos` differs from the polarity sample. If that happens on count k (counting from 0), de-integrate has lasted k+1 counts and the reading is k. The reading is held in BCD: `rdg_dec[3:0]` units, `[7:4]` tens, `[11:8]` hundreds, with `rdg_thou` as the thousands bit.
- R7: If no change is seen within 2000 counts, de-integrate ends after exactly 2000 counts, with `rdg_ovr`=1, `rdg_thou`=1 and `rdg_dec`=0.
- R8: Zero-integrator lasts ZI_NORM counts (35, or 140 clocks) after a normal reading and ZI_HEAVY counts (185, or 740 clocks) after an overrange.
- R9: Auto-zero takes up the rest of the cycle, so successive starts of signal integrate are always CYCLE_COUNTS counts (16000 clocks) apart.
- R10: The reading outputs change only in the clock after de-integrate ends. At every other time they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_pos | input | 1 | Comparator: 1 when the integrator output is above zero |
| en_az | output | 1 | Auto-zero switch enable |
| en_int | output | 1 | Signal integrate switch enable |
| en_de_pos | output | 1 | De-integrate enable, reference that discharges a positive integral |
| en_de_neg | output | 1 | De-integrate enable, reference that discharges a negative integral |
| en_zi | output | 1 | Zero-integrator switch enable |
| rdg_dec | output | 4*DIGITS | Latched BCD decades, units in the low nibble |
| rdg_thou | output | 1 | Latched thousands bit |
| rdg_neg | output | 1 | Latched sign, 1 for a negative input |
| rdg_ovr | output | 1 | Latched overrange flag |

## Verification
A wrong count in the cycle position shows up within one conversion as a signal integrate or auto-zero length that differs from the expected number of clocks. It also shifts the spacing between successive integrate starts away from 16000 clocks. A polarity sample taken on the wrong count, or a reversed polarity, shows up at the start of de-integrate as the wrong enable, and in the sign bit that is latched a few thousand clocks later. A broken decade carry or a mis-timed load is visible in the reading one clock after de-integrate ends. A lost overrange state shows up as a zero-integrator phase that is 600 clocks too short.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    // One-hot phase encoding: each bit is a switch enable
    typedef enum logic [4:0] {
        PH_AZ  = 5'b00001,
        PH_INT = 5'b00010,
        PH_DEP = 5'b00100,
        PH_DEN = 5'b01000,
        PH_ZI  = 5'b10000
    } phase_e;

    typedef struct packed {
        logic zi;
        logic de_neg;
        logic de_pos;
        logic integ;
        logic az;
    } phase_en_t;

    typedef logic [3:0] bcd_t;

    function automatic phase_en_t phase_enables(phase_e p);
        return phase_en_t'(p);
    endfunction

    function automatic logic bcd_is_nine(bcd_t d);
        return d == 4'd9;
    endfunction

    function automatic bcd_t bcd_next(bcd_t d);
        return (d == 4'd9) ? 4'd0 : d + 4'd1;
    endfunction

endpackage

// File: rtl/dsc_prescale.sv
module dsc_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (cnt == W'(DIV-1)) cnt <= '0;
        else                       cnt <= cnt + W'(1);
    end

    assign tick = (cnt == W'(DIV-1));

    generate
        if (DIV > 1) begin : g_gap
            // R3: count ticks never come on adjacent clocks
            a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/dsc_bcd_count.sv
module dsc_bcd_count
    import dsc_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  inc,
    output logic [4*DIGITS-1:0]   dec,
    output logic                  half,
    output logic                  full
);
    logic [DIGITS:0]   carry;
    logic [DIGITS-1:0] nine;

    assign carry[0] = inc;

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_dec
            bcd_t d;
            always_ff @(posedge clk) begin
                if (rst || clr)    d <= '0;
                else if (carry[g]) d <= bcd_next(d);
            end
            assign nine[g]      = bcd_is_nine(d);
            assign carry[g+1]   = carry[g] & nine[g];
            assign dec[4*g +: 4] = d;
        end
    endgenerate

    // Half digit: the leading 1 of a 3.5-digit reading
    always_ff @(posedge clk) begin
        if (rst || clr)        half <= 1'b0;
        else if (carry[DIGITS]) half <= 1'b1;
    end

    assign full = half & (&nine);

    // R6: the controller never asks for a count past the top of the range
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        inc |-> !full);
endmodule

// File: rtl/dsc_phase_ctrl.sv
module dsc_phase_ctrl
    import dsc_pkg::*;
#(
    parameter int INT_COUNTS   = 1000,
    parameter int CYCLE_COUNTS = 4000,
    parameter int ZI_NORM      = 35,
    parameter int ZI_HEAVY     = 185
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   cmp_pos,
    input  logic   cnt_full,
    output phase_e phase,
    output logic   cnt_clr,
    output logic   cnt_inc,
    output logic   res_load,
    output logic   res_ovr,
    output logic   pol_pos
);
    localparam int PW        = $clog2(CYCLE_COUNTS);
    localparam int ZW        = $clog2(ZI_HEAVY + 1);
    localparam int POS_RESET = CYCLE_COUNTS - INT_COUNTS;

    logic [PW-1:0] pos;
    logic [ZW-1:0] zcnt;
    logic          pol_q;
    logic          heavy_q;

    logic          in_de;
    logic          crossed;
    logic          last_pos;
    logic [ZW-1:0] zi_limit;

    assign in_de    = (phase == PH_DEP) || (phase == PH_DEN);
    assign crossed  = (cmp_pos != pol_q);
    assign last_pos = (pos == PW'(CYCLE_COUNTS - 1));
    assign zi_limit = heavy_q ? ZW'(ZI_HEAVY - 1) : ZW'(ZI_NORM - 1);

    assign cnt_clr  = tick && (phase == PH_AZ) && last_pos;
    assign cnt_inc  = tick && in_de && !crossed && !cnt_full;
    assign res_load = tick && in_de && (crossed || cnt_full);
    assign res_ovr  = !crossed;
    assign pol_pos  = pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_AZ;
            pos     <= PW'(POS_RESET);
            zcnt    <= '0;
            pol_q   <= 1'b1;
            heavy_q <= 1'b0;
        end else if (tick) begin
            pos <= last_pos ? '0 : pos + PW'(1);
            unique case (phase)
                PH_AZ: begin
                    if (last_pos) phase <= PH_INT;
                end
                PH_INT: begin
                    if (pos == PW'(INT_COUNTS - 1)) begin
                        pol_q <= cmp_pos;
                        phase <= cmp_pos ? PH_DEP : PH_DEN;
                    end
                end
                PH_DEP, PH_DEN: begin
                    if (crossed || cnt_full) begin
                        heavy_q <= !crossed;
                        zcnt    <= '0;
                        phase   <= PH_ZI;
                    end
                end
                PH_ZI: begin
                    if (zcnt == zi_limit) begin
                        zcnt  <= '0;
                        phase <= PH_AZ;
                    end else begin
                        zcnt <= zcnt + ZW'(1);
                    end
                end
                default: phase <= PH_AZ;
            endcase
        end
    end

    // R5: the de-integrate polarity matches the sample taken at the end of integrate
    a_r5_pos_ref: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DEP) |-> pol_q);
    a_r5_neg_ref: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DEN) |-> !pol_q);
    // R9: signal integrate always begins at cycle position zero
    a_r9_int_start: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_AZ && phase == PH_INT) |-> (pos == '0 || tick));
endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
    import dsc_pkg::*;
#(
    parameter int DIV          = 4,
    parameter int DIGITS       = 3,
    parameter int INT_COUNTS   = 1000,
    parameter int CYCLE_COUNTS = 4000,
    parameter int ZI_NORM      = 35,
    parameter int ZI_HEAVY     = 185
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmp_pos,
    output logic                en_az,
    output logic                en_int,
    output logic                en_de_pos,
    output logic                en_de_neg,
    output logic                en_zi,
    output logic [4*DIGITS-1:0] rdg_dec,
    output logic                rdg_thou,
    output logic                rdg_neg,
    output logic                rdg_ovr
);
    localparam int DE_MAX = 2 * (10 ** DIGITS);
    localparam int RW     = $clog2(CYCLE_COUNTS * DIV) + 1;

    logic                tick;
    phase_e              phase;
    phase_en_t           en;
    logic                cnt_clr, cnt_inc, cnt_full, cnt_half;
    logic [4*DIGITS-1:0] cnt_dec;
    logic                res_load, res_ovr, pol_pos;

    dsc_prescale #(.DIV(DIV)) u_pre (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    dsc_phase_ctrl #(
        .INT_COUNTS  (INT_COUNTS),
        .CYCLE_COUNTS(CYCLE_COUNTS),
        .ZI_NORM     (ZI_NORM),
        .ZI_HEAVY    (ZI_HEAVY)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cmp_pos (cmp_pos),
        .cnt_full(cnt_full),
        .phase   (phase),
        .cnt_clr (cnt_clr),
        .cnt_inc (cnt_inc),
        .res_load(res_load),
        .res_ovr (res_ovr),
        .pol_pos (pol_pos)
    );

    dsc_bcd_count #(.DIGITS(DIGITS)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (cnt_inc),
        .dec (cnt_dec),
        .half(cnt_half),
        .full(cnt_full)
    );

    assign en        = phase_enables(phase);
    assign en_az     = en.az;
    assign en_int    = en.integ;
    assign en_de_pos = en.de_pos;
    assign en_de_neg = en.de_neg;
    assign en_zi     = en.zi;

    // Output latch: loaded only when de-integrate finishes
    always_ff @(posedge clk) begin
        if (rst) begin
            rdg_dec  <= '0;
            rdg_thou <= 1'b0;
            rdg_neg  <= 1'b0;
            rdg_ovr  <= 1'b0;
        end else if (res_load) begin
            rdg_neg  <= !pol_pos;
            rdg_ovr  <= res_ovr;
            rdg_dec  <= res_ovr ? '0 : cnt_dec;
            rdg_thou <= res_ovr ? 1'b1 : cnt_half;
        end
    end

    // Observers for the timing assertions
    phase_e        phase_prev;
    logic [RW-1:0] run_len;
    logic          int_prev, seen_int;
    logic [RW-1:0] period;
    logic          de_any;

    assign de_any = en.de_pos | en.de_neg;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_prev <= PH_AZ;
            run_len    <= '0;
            int_prev   <= 1'b0;
            seen_int   <= 1'b0;
            period     <= '0;
        end else begin
            phase_prev <= phase;
            run_len    <= (phase != phase_prev) ? RW'(1) : run_len + RW'(1);
            int_prev   <= en.integ;
            seen_int   <= seen_int | (en.integ & !int_prev);
            period     <= (en.integ && !int_prev) ? RW'(1) : period + RW'(1);
        end
    end

    a_r2_one_phase: assert property (@(posedge clk) disable iff (rst)
        $onehot({en_az, en_int, en_de_pos, en_de_neg, en_zi}));
    a_r4_int_len: assert property (@(posedge clk) disable iff (rst)
        $fell(en_int) |-> run_len == RW'(INT_COUNTS * DIV));
    a_r7_de_cap: assert property (@(posedge clk) disable iff (rst)
        de_any |-> run_len <= RW'(DE_MAX * DIV));
    a_r7_ovr_code: assert property (@(posedge clk) disable iff (rst)
        rdg_ovr |-> (rdg_thou && rdg_dec == '0));
    a_r8_zi_len: assert property (@(posedge clk) disable iff (rst)
        $fell(en_zi) |-> run_len == RW'((rdg_ovr ? ZI_HEAVY : ZI_NORM) * DIV));
    a_r9_period: assert property (@(posedge clk) disable iff (rst)
        (en_int && !int_prev && seen_int) |-> period == RW'(CYCLE_COUNTS * DIV));
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !$fell(de_any) |-> $stable({rdg_dec, rdg_thou, rdg_neg, rdg_ovr}));
endmodule

// File: tb/dsc_sequencer_test.sv
module dsc_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_pos = 1'b1;
    logic        en_az, en_int, en_de_pos, en_de_neg, en_zi;
    logic [11:0] rdg_dec;
    logic        rdg_thou, rdg_neg, rdg_ovr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int onehot_bad = 0;
    int last_int = -1;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dsc_sequencer uut (
        .clk(clk), .rst(rst), .cmp_pos(cmp_pos),
        .en_az(en_az), .en_int(en_int), .en_de_pos(en_de_pos),
        .en_de_neg(en_de_neg), .en_zi(en_zi),
        .rdg_dec(rdg_dec), .rdg_thou(rdg_thou), .rdg_neg(rdg_neg), .rdg_ovr(rdg_ovr)
    );

    always @(negedge clk)
        if (!rst && $countones({en_az, en_int, en_de_pos, en_de_neg, en_zi}) != 1)
            onehot_bad++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_bcd(input int n);
        return ((n / 100) % 10) * 256 + ((n / 10) % 10) * 16 + (n % 10);
    endfunction

    function automatic int snap();
        return {rdg_dec, rdg_thou, rdg_neg, rdg_ovr};
    endfunction

    // n < 0: comparator never changes side (overrange)
    task automatic conv(input int n, input bit posi);
        int il = 0, dl = 0, zl = 0, al = 0, held, moved = 0;
        int exp_de, exp_zi;
        cmp_pos = posi;
        held = snap();
        if (last_int >= 0) chk(cyc - last_int == 16000, "R9 period", cyc - last_int, 16000);
        last_int = cyc;
        while (en_int) begin
            if (snap() != held) moved++;
            il++; @(negedge clk);
        end
        chk(il == 4000, "R4 integrate length", il, 4000);
        chk(en_de_pos == posi && en_de_neg == !posi, "R5 reference select",
            {en_de_pos, en_de_neg}, {posi, !posi});
        while (en_de_pos || en_de_neg) begin
            if (n >= 0 && dl == 4 * n) cmp_pos = ~posi;
            if (snap() != held) moved++;
            dl++; @(negedge clk);
        end
        exp_de = (n >= 0) ? 4 * (n + 1) : 8000;
        chk(dl == exp_de, (n >= 0) ? "R6 de-integrate length" : "R7 de-integrate cap", dl, exp_de);
        chk(dl % 4 == 0, "R3 count boundary", dl % 4, 0);
        chk(rdg_neg == !posi, "R5 sign", rdg_neg, !posi);
        if (n >= 0) begin
            chk(rdg_ovr == 1'b0, "R6 no overrange", rdg_ovr, 0);
            chk(int'(rdg_dec) == exp_bcd(n), "R6 decades", rdg_dec, exp_bcd(n));
            chk(rdg_thou == (n >= 1000), "R6 thousands", rdg_thou, n >= 1000);
        end else begin
            chk(rdg_ovr == 1'b1, "R7 overrange flag", rdg_ovr, 1);
            chk(rdg_thou == 1'b1 && rdg_dec == 12'd0, "R7 overrange code",
                {rdg_thou, rdg_dec}, 13'h1000);
        end
        held = snap();
        while (en_zi) begin
            if (snap() != held) moved++;
            zl++; @(negedge clk);
        end
        exp_zi = (n >= 0) ? 140 : 740;
        chk(zl == exp_zi, "R8 zero-integrator length", zl, exp_zi);
        while (en_az) begin
            if (snap() != held) moved++;
            al++; @(negedge clk);
        end
        chk(al == 16000 - 4000 - dl - zl, "R9 auto-zero fill", al, 16000 - 4000 - dl - zl);
        chk(moved == 0, "R10 reading held", moved, 0);
    endtask

    initial begin
        int al = 0;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk(en_az && !en_int && !en_de_pos && !en_de_neg && !en_zi, "R1 reset phase",
            {en_az, en_int, en_de_pos, en_de_neg, en_zi}, 5'b10000);
        chk(rdg_dec == 0 && !rdg_thou && !rdg_neg && !rdg_ovr, "R1 reset reading",
            {rdg_dec, rdg_thou, rdg_neg, rdg_ovr}, 0);
        rst = 1'b0;
        while (en_az) begin
            al++; @(negedge clk);
        end
        chk(al == 4000, "R1 first auto-zero", al, 4000);
        conv(0, 1'b1);
        conv(1999, 1'b0);
        conv(-1, 1'b1);
        conv(537, 1'b0);
        for (int i = 0; i < 4; i++) conv(int'($urandom % 2000), 1'($urandom % 2));
        chk(onehot_bad == 0, "R2 single phase", onehot_bad, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cyc >= 190000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule